// File: doc/BRIEF.md
# Double-Buffered PWM Reload Controller

This block produces one edge-aligned PWM output. Software sets it up through a small register bus: a period modulus, a clock prescaler, a duty value, and a selector for how often a reload happens. The modulus, the prescaler and the duty go into shadow registers. They reach the running generator only at a reload boundary, and only when software has set a load-permission bit. The block clears that bit by itself once the transfer is done, so the generator never runs on a half-updated set of parameters.

A reload boundary comes every 1, 2, 4 or 8 PWM periods. The reload-rate selector is buffered as well. A new value takes effect only after the reload interval already in progress has finished. Every reload sets a sticky flag, which can drive an interrupt request. Software clears the flag with a read followed by a write of 0.

Top module: `pwm_reload_ctrl`

## Requirements
- R1: Writing the modulus (address 1), the duty (address 2) or the prescaler (control bits 7:6) changes only the shadow copy. The PWM output keeps its waveform until a reload occurs while the permission bit is set. A read of address 1 or 2 returns the shadow value.
- R2: At a reload with the permission bit (control bit 1) set, the shadow modulus, duty and prescaler become active together. The permission bit then reads 0. Writing 0 to that bit has no effect.
- R3: The reload interval is 2^S PWM periods, where S is control bits 5:4. A new S is used only from the reload that ends the interval in progress.
- R4: A read of control bits 5:4 returns the last value written, even while the active rate still differs.
- R5: Every reload sets the flag (control bit 3). The interrupt output is high exactly when the flag and interrupt-enable (control bit 2) are both 1.
- R6: With interrupt-enable at 0, reloads still set the flag but the interrupt output stays low.
- R7: The flag clears only on a control write with bit 3 at 0 that follows a control read made while the flag was 1. A write of 0 without that read leaves the flag set.
- R8: Setting the enable (control bit 0) from 0 to 1 causes an immediate reload. The shadow values, including any in that same write, are loaded if permission is set. The flag is set whether or not a load happens.
- R9: The PWM period is M·2^P clocks, where M is the active modulus (0 and 1 both give one count) and P is the active prescaler code. The output is high for min(D,M)·2^P clocks per period, starting at the period start, where D is the active duty. It is constant low when D is 0 or the block is disabled.
- R10: If a flag-clearing write falls in the same clock as a reload, the flag stays 1.
- R11: After reset the control register reads 0, and the PWM and interrupt outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (arms flag clearing) |
| bus_addr | input | 2 | Register select: 0 control, 1 modulus, 2 duty |
| bus_wdata | input | W | Write data |
| bus_rdata | output | W | Combinational read data |
| pwm_o | output | 1 | PWM output |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the block with W = 8, its default. At that width, moduli of 1 to 10 with every prescaler code give PWM periods short enough to measure over two full periods each. A modulus of 4 makes reloads only 4 to 32 clocks apart, so the deferred switch of the reload rate shows up in measured intervals. A modulus of 200 gives the read-then-write clear sequence room between reloads. It also lets a clearing write be placed on the exact reload clock.

// File: rtl/pwm_reload_ctrl.sv
module pwm_reload_ctrl #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bus_wr,
  input  logic         bus_rd,
  input  logic [1:0]   bus_addr,
  input  logic [W-1:0] bus_wdata,
  output logic [W-1:0] bus_rdata,
  output logic         pwm_o,
  output logic         irq_o
);
  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_MOD  = 2'd1;
  localparam logic [1:0] A_DUTY = 2'd2;

  logic         en, ldok, ien, flag, armed;
  logic [1:0]   lf_s, lf_a, ps_s, ps_a;
  logic [W-1:0] mod_s, mod_a, duty_s, duty_a, cnt;
  logic [2:0]   pre, per;

  wire wr_ctrl = bus_wr && bus_addr == A_CTRL;
  wire rd_ctrl = bus_rd && bus_addr == A_CTRL;
  wire start   = wr_ctrl && bus_wdata[0] && !en;

  wire [1:0]   ps_n   = wr_ctrl ? bus_wdata[7:6] : ps_s;
  wire [1:0]   lf_n   = wr_ctrl ? bus_wdata[5:4] : lf_s;
  wire [W-1:0] mod_n  = (bus_wr && bus_addr == A_MOD)  ? bus_wdata : mod_s;
  wire [W-1:0] duty_n = (bus_wr && bus_addr == A_DUTY) ? bus_wdata : duty_s;
  wire         ldok_n = ldok || (wr_ctrl && bus_wdata[1]);

  wire [3:0] pre_lim = (4'd1 << ps_a) - 4'd1;
  wire [3:0] per_lim = (4'd1 << lf_a) - 4'd1;
  wire       tick    = {1'b0, pre} == pre_lim;
  wire [W:0] cnt_inc = {1'b0, cnt} + 1'b1;
  wire       wrap    = cnt_inc >= {1'b0, mod_a};
  wire       pend    = en && tick && wrap;
  wire       reload  = start || (pend && {1'b0, per} == per_lim);
  wire       do_load = reload && ldok_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en <= 1'b0; ien <= 1'b0; ldok <= 1'b0; flag <= 1'b0; armed <= 1'b0;
      lf_s <= '0; lf_a <= '0; ps_s <= '0; ps_a <= '0;
      mod_s <= '0; mod_a <= '0; duty_s <= '0; duty_a <= '0;
      cnt <= '0; pre <= '0; per <= '0;
    end else begin
      ps_s   <= ps_n;
      lf_s   <= lf_n;
      mod_s  <= mod_n;
      duty_s <= duty_n;
      if (wr_ctrl) begin
        en  <= bus_wdata[0];
        ien <= bus_wdata[2];
      end
      ldok <= do_load ? 1'b0 : ldok_n;
      if (do_load) begin
        mod_a  <= mod_n;
        duty_a <= duty_n;
        ps_a   <= ps_n;
      end
      if (reload) lf_a <= lf_n;

      if (reload) flag <= 1'b1;
      else if (wr_ctrl && !bus_wdata[3] && armed) flag <= 1'b0;
      if (wr_ctrl) armed <= 1'b0;
      else if (rd_ctrl && flag) armed <= 1'b1;

      if (start || !en) begin
        pre <= '0; cnt <= '0; per <= '0;
      end else if (tick) begin
        pre <= '0;
        if (wrap) begin
          cnt <= '0;
          per <= ({1'b0, per} == per_lim) ? 3'd0 : per + 3'd1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end else begin
        pre <= pre + 3'd1;
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      A_CTRL:  bus_rdata[7:0] = {ps_s, lf_s, flag, ien, ldok, en};
      A_MOD:   bus_rdata = mod_s;
      A_DUTY:  bus_rdata = duty_s;
      default: bus_rdata = '0;
    endcase
  end

  assign pwm_o = en && cnt < duty_a;
  assign irq_o = flag && ien;
endmodule

// File: rtl/pwm_reload_ctrl_chk.sv
module pwm_reload_ctrl_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         reload,
  input logic         wr_ctrl,
  input logic         en,
  input logic         ldok,
  input logic         ien,
  input logic         flag,
  input logic [1:0]   ps_a,
  input logic [1:0]   lf_a,
  input logic [W-1:0] mod_a,
  input logic [W-1:0] duty_a,
  input logic         pwm_o,
  input logic         irq_o
);
  a_r1_active_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !reload |=> $stable(mod_a) && $stable(duty_a) && $stable(ps_a));
  a_r2_ldok_drops: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> !ldok);
  a_r3_rate_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !reload |=> $stable(lf_a));
  a_r5_flag_on_reload: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> flag);
  a_r6_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !ien |-> !irq_o);
  a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    flag && !wr_ctrl |=> flag);
  a_r9_zero_duty_low: assert property (@(posedge clk) disable iff (!rst_n)
    duty_a == '0 |-> !pwm_o);
  a_r9_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !pwm_o);
endmodule

bind pwm_reload_ctrl pwm_reload_ctrl_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reload(reload), .wr_ctrl(wr_ctrl), .en(en),
  .ldok(ldok), .ien(ien), .flag(flag), .ps_a(ps_a), .lf_a(lf_a),
  .mod_a(mod_a), .duty_a(duty_a), .pwm_o(pwm_o), .irq_o(irq_o)
);

// File: tb/pwm_reload_ctrl_tb.sv
`timescale 1ns/100ps
module pwm_reload_ctrl_tb;
  localparam int W = 8;
  localparam int NV = 8;
  // mod, duty, prescaler code, high clocks per period
  localparam int VEC [NV][4] = '{
    '{10, 3, 0, 3}, '{10, 0, 0, 0}, '{10, 10, 0, 10}, '{10, 15, 1, 20},
    '{5, 2, 2, 8},  '{4, 1, 3, 8},  '{1, 1, 0, 1},    '{7, 6, 1, 12}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0] bus_addr = '0;
  logic [W-1:0] bus_wdata = '0;
  logic [W-1:0] bus_rdata;
  logic pwm_o, irq_o;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  pwm_reload_ctrl #(.W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pwm_o(pwm_o), .irq_o(irq_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic hi_count(input int n, output int h);
    h = 0;
    repeat (n) begin
      h += int'(pwm_o);
      @(negedge clk);
    end
  endtask

  task automatic measure(input logic [7:0] base, output int n, output logic [7:0] seen);
    rd(2'd0, seen);
    wr(2'd0, base & 8'hF7);
    n = 2;
    while (!irq_o && n < 1000) begin
      @(negedge clk);
      n++;
    end
  endtask

  initial begin
    #750000;
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int h, n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    rd(2'd0, d);
    chk("R11 ctrl", int'(d), 0);
    chk("R11 pwm", int'(pwm_o), 0);
    chk("R11 irq", int'(irq_o), 0);

    for (int i = 0; i < NV; i++) begin
      wr(2'd1, 8'(VEC[i][0]));
      wr(2'd2, 8'(VEC[i][1]));
      wr(2'd0, 8'(VEC[i][2] << 6) | 8'h0B);
      hi_count(2 * (VEC[i][0] << VEC[i][2]), h);
      chk("R9 high clocks", h, 2 * VEC[i][3]);
      rd(2'd0, d);
      chk("R8 ldok cleared by start load", int'(d[1]), 0);
      chk("R8 flag set at start", int'(d[3]), 1);
      wr(2'd0, 8'h08);
    end

    // interlock
    wr(2'd1, 8'd4); wr(2'd2, 8'd2); wr(2'd0, 8'h0B);
    hi_count(8, h);
    chk("R9 base waveform", h, 4);
    wr(2'd2, 8'd4);
    repeat (10) @(negedge clk);
    hi_count(8, h);
    chk("R1 duty held without permission", h, 4);
    rd(2'd2, d);
    chk("R1 shadow readback", int'(d), 4);
    wr(2'd0, 8'h0B);
    repeat (6) @(negedge clk);
    rd(2'd0, d);
    chk("R2 permission self-clears", int'(d[1]), 0);
    hi_count(8, h);
    chk("R2 new duty applied", h, 8);
    wr(2'd0, 8'h08);

    // enable without permission: flag/irq but no load
    wr(2'd1, 8'd200); wr(2'd2, 8'd100); wr(2'd0, 8'h0D);
    chk("R8 irq at enable", int'(irq_o), 1);
    chk("R8 no load without permission", int'(pwm_o), 1);
    wr(2'd0, 8'h0F);
    repeat (6) @(negedge clk);
    wr(2'd0, 8'h05);
    chk("R7 write 0 without read keeps flag", int'(irq_o), 1);
    rd(2'd0, d);
    wr(2'd0, 8'h05);
    chk("R7 read then write 0 clears", int'(irq_o), 0);
    n = 0;
    while (!irq_o && n < 1000) begin @(negedge clk); n++; end
    chk("R5 irq on next reload", int'(irq_o), 1);
    rd(2'd0, d);
    repeat (198) @(negedge clk);
    wr(2'd0, 8'h05);
    chk("R10 set wins over clear", int'(irq_o), 1);
    rd(2'd0, d);
    wr(2'd0, 8'h01);
    chk("R6 flag cleared, irq low", int'(irq_o), 0);
    h = 0;
    repeat (250) begin h += int'(irq_o); @(negedge clk); end
    chk("R6 no irq while disabled", h, 0);
    rd(2'd0, d);
    chk("R6 flag still set by reloads", int'(d[3]), 1);
    wr(2'd0, 8'h08);

    // reload-rate buffering
    wr(2'd1, 8'd4); wr(2'd2, 8'd1); wr(2'd0, 8'h0F);
    chk("R5 irq with enable", int'(irq_o), 1);
    measure(8'h25, n, d);
    chk("R3 old rate completes", n, 4);
    measure(8'h15, n, d);
    chk("R4 readback of pending rate", int'(d[5:4]), 2);
    chk("R3 rate 2 interval", n, 16);
    measure(8'h15, n, d);
    chk("R4 readback rate 1", int'(d[5:4]), 1);
    chk("R3 rate 1 interval", n, 8);
    measure(8'h15, n, d);
    chk("R3 rate 1 steady", n, 8);
    wr(2'd0, 8'h08);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule